// File: doc/BRIEF.md
# Transaction Read/Write Signature Unit

This block keeps a compact, lossy record of which addresses one transaction has loaded from and which it has stored to. Each record is a fixed-width hashed bit vector (a Bloom-filter signature): every tracked address turns on one bit in each of several equal banks. Load addresses go into the read signature and store addresses go into the write signature. Both are wiped together when the transaction commits or aborts.

When another transaction commits, its write signature is presented on the remote input. The block intersects it with both local signatures in a single cycle and raises a registered conflict flag if either could overlap. Hashing may report a conflict that did not happen, but it never misses one that did. The local write signature is driven out continuously so the owner can broadcast it at its own commit. A single-address probe port answers "possibly present" for each local signature.

Top module: `bloom_sig_unit`

## Requirements
- R1: After reset both signatures are all zero, `wr_sig` is zero, `conflict` is low and a probe of any address reports no hit in either set.
- R2: With defaults (32-bit address, 4 banks of 512 bits), the index for bank k is obtained by rotating the address left by 5*k bits and XOR-ing its 9-bit slices together (slice j = bits 9j..9j+8, the top slice zero-padded); the inserted bit is signature bit k*512 + index.
- R3: A load with `ld_valid` high sets its four bits in the read signature only; a store with `st_valid` high sets its four bits in the write signature only, visible on `wr_sig` the cycle after the edge. Bits once set stay set until a clear.
- R4: `probe_rd_hit` / `probe_wr_hit` are high exactly when all four hashed bits of `probe_addr` are set in the read / write signature; an inserted address always hits.
- R5: `conflict` is registered: one cycle after an edge with `rmt_valid` high it is high exactly when the remote signature intersects the read signature or the write signature held before that edge.
- R6: `conflict` is low in the cycle after any edge where `rmt_valid` is low.
- R7: `clr` zeroes both signatures in one cycle; a load or store in the same cycle as `clr` is present afterwards and nothing older is.
- R8: Two signatures intersect only if every bank has at least one bit set in both; a single bank with an empty AND gives no conflict even when all other banks overlap.
- R9: A remote signature holding any locally loaded or stored address always produces a conflict (no false negatives).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Commit/abort wipe of both signatures |
| ld_valid | input | 1 | Load address valid |
| ld_addr | input | 32 | Load address |
| st_valid | input | 1 | Store address valid |
| st_addr | input | 32 | Store address |
| rmt_valid | input | 1 | Remote write signature valid for testing |
| rmt_sig | input | 2048 | Remote committing write signature |
| probe_addr | input | 32 | Address for membership probe |
| probe_rd_hit | output | 1 | Probe address possibly in read set |
| probe_wr_hit | output | 1 | Probe address possibly in write set |
| conflict | output | 1 | Registered conflict result |
| wr_sig | output | 2048 | Local write signature for broadcast |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, four banks of 512 bits and a rotate step of 5, so the full 2048-bit signatures are compared bit for bit against a model built from the hash rule in R2. These sizes keep accidental collisions rare enough that handcrafted remote signatures can overlap the local set in exactly three banks, exposing the every-bank rule, while real inserted addresses probe the no-false-negative guarantee.

// File: rtl/sig_pkg.sv
package sig_pkg;
    localparam int unsigned DEF_ADDR_W   = 32;
    localparam int unsigned DEF_BANKS    = 4;
    localparam int unsigned DEF_BANK_W   = 512;
    localparam int unsigned DEF_ROT_STEP = 5;

    // Probe answer for both local sets
    typedef struct packed {
        logic rd;
        logic wr;
    } probe_hit_t;

    // Which local set an insert port feeds
    typedef enum logic {
        SET_READ  = 1'b0,
        SET_WRITE = 1'b1
    } set_sel_t;
endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BANKS    = 4,
    parameter int unsigned BANK_W   = 512,
    parameter int unsigned ROT_STEP = 5,
    localparam int unsigned IDX_W   = $clog2(BANK_W)
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic [BANKS*IDX_W-1:0] idx
);
    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        localparam int unsigned ROT = (k * ROT_STEP) % ADDR_W;
        logic [ADDR_W-1:0] rot;
        logic [IDX_W-1:0]  fold;
        always_comb begin
            for (int i = 0; i < ADDR_W; i++) begin
                rot[(i + ROT) % ADDR_W] = addr[i];
            end
            fold = '0;
            for (int i = 0; i < ADDR_W; i++) begin
                fold[i % IDX_W] = fold[i % IDX_W] ^ rot[i];
            end
        end
        assign idx[k*IDX_W +: IDX_W] = fold;
    end
endmodule

// File: rtl/sig_store.sv
module sig_store #(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned BANK_W = 512,
    localparam int unsigned IDX_W = $clog2(BANK_W),
    localparam int unsigned SIG_W = BANKS * BANK_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   ins_valid,
    input  logic [BANKS*IDX_W-1:0] ins_idx,
    output logic [SIG_W-1:0]       sig
);
    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        logic [BANK_W-1:0] slice;
        logic [BANK_W-1:0] ins_bit;
        assign ins_bit = ins_valid ? (BANK_W'(1) << ins_idx[k*IDX_W +: IDX_W]) : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                slice <= '0;
            end else if (clr || ins_valid) begin
                slice <= (clr ? '0 : slice) | ins_bit;
            end
        end
        assign sig[k*BANK_W +: BANK_W] = slice;
    end
endmodule

// File: rtl/sig_overlap.sv
module sig_overlap #(
    parameter int unsigned BANKS  = 4,
    parameter int unsigned BANK_W = 512,
    localparam int unsigned SIG_W = BANKS * BANK_W
) (
    input  logic [SIG_W-1:0] a,
    input  logic [SIG_W-1:0] b,
    output logic             hit
);
    logic [BANKS-1:0] bank_any;
    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        assign bank_any[k] = |(a[k*BANK_W +: BANK_W] & b[k*BANK_W +: BANK_W]);
    end
    assign hit = &bank_any;
endmodule

// File: rtl/bloom_sig_unit.sv
module bloom_sig_unit
    import sig_pkg::*;
#(
    parameter int unsigned ADDR_W   = DEF_ADDR_W,
    parameter int unsigned BANKS    = DEF_BANKS,
    parameter int unsigned BANK_W   = DEF_BANK_W,
    parameter int unsigned ROT_STEP = DEF_ROT_STEP,
    localparam int unsigned IDX_W   = $clog2(BANK_W),
    localparam int unsigned SIG_W   = BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              rmt_valid,
    input  logic [SIG_W-1:0]  rmt_sig,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_rd_hit,
    output logic              probe_wr_hit,
    output logic              conflict,
    output logic [SIG_W-1:0]  wr_sig
);
    logic [BANKS*IDX_W-1:0] ld_idx, st_idx, pr_idx;
    logic [SIG_W-1:0]       rd_sig;
    logic                   ov_rd, ov_wr;
    probe_hit_t             pr_hit;
    logic                   conflict_q;

    sig_hash #(.ADDR_W(ADDR_W), .BANKS(BANKS), .BANK_W(BANK_W), .ROT_STEP(ROT_STEP))
        u_hash_ld (.addr(ld_addr), .idx(ld_idx));
    sig_hash #(.ADDR_W(ADDR_W), .BANKS(BANKS), .BANK_W(BANK_W), .ROT_STEP(ROT_STEP))
        u_hash_st (.addr(st_addr), .idx(st_idx));
    sig_hash #(.ADDR_W(ADDR_W), .BANKS(BANKS), .BANK_W(BANK_W), .ROT_STEP(ROT_STEP))
        u_hash_pr (.addr(probe_addr), .idx(pr_idx));

    sig_store #(.BANKS(BANKS), .BANK_W(BANK_W)) u_rd_set (
        .clk(clk), .rst(rst), .clr(clr),
        .ins_valid(ld_valid), .ins_idx(ld_idx), .sig(rd_sig));
    sig_store #(.BANKS(BANKS), .BANK_W(BANK_W)) u_wr_set (
        .clk(clk), .rst(rst), .clr(clr),
        .ins_valid(st_valid), .ins_idx(st_idx), .sig(wr_sig));

    sig_overlap #(.BANKS(BANKS), .BANK_W(BANK_W)) u_ov_rd (
        .a(rmt_sig), .b(rd_sig), .hit(ov_rd));
    sig_overlap #(.BANKS(BANKS), .BANK_W(BANK_W)) u_ov_wr (
        .a(rmt_sig), .b(wr_sig), .hit(ov_wr));

    // Probe: every bank's hashed bit must be set
    always_comb begin
        pr_hit.rd = 1'b1;
        pr_hit.wr = 1'b1;
        for (int k = 0; k < BANKS; k++) begin
            pr_hit.rd = pr_hit.rd & rd_sig[k*BANK_W + int'(pr_idx[k*IDX_W +: IDX_W])];
            pr_hit.wr = pr_hit.wr & wr_sig[k*BANK_W + int'(pr_idx[k*IDX_W +: IDX_W])];
        end
    end
    assign probe_rd_hit = pr_hit.rd;
    assign probe_wr_hit = pr_hit.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            conflict_q <= 1'b0;
        end else begin
            conflict_q <= rmt_valid && (ov_rd || ov_wr);
        end
    end
    assign conflict = conflict_q;
endmodule

// File: rtl/sig_unit_checker.sv
module sig_unit_checker #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BANKS    = 4,
    parameter int unsigned BANK_W   = 512,
    parameter int unsigned ROT_STEP = 5,
    localparam int unsigned IDX_W   = $clog2(BANK_W),
    localparam int unsigned SIG_W   = BANKS * BANK_W
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              st_valid,
    input logic [ADDR_W-1:0] st_addr,
    input logic              rmt_valid,
    input logic              conflict,
    input logic [SIG_W-1:0]  wr_sig
);
    logic                   st_seen_q;
    logic [ADDR_W-1:0]      st_addr_q;
    logic [BANKS*IDX_W-1:0] chk_idx;
    logic                   st_present;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_seen_q <= 1'b0;
            st_addr_q <= '0;
        end else begin
            st_seen_q <= st_valid;
            st_addr_q <= st_addr;
        end
    end

    sig_hash #(.ADDR_W(ADDR_W), .BANKS(BANKS), .BANK_W(BANK_W), .ROT_STEP(ROT_STEP))
        u_chk_hash (.addr(st_addr_q), .idx(chk_idx));

    always_comb begin
        st_present = 1'b1;
        for (int k = 0; k < BANKS; k++) begin
            st_present = st_present & wr_sig[k*BANK_W + int'(chk_idx[k*IDX_W +: IDX_W])];
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!conflict && wr_sig == '0)); // R1
    AST_STORE_VISIBLE: assert property (@(posedge clk) disable iff (rst) st_seen_q |-> st_present); // R3
    AST_WR_STICKY: assert property (@(posedge clk) disable iff (rst) !clr |=> (($past(wr_sig) & ~wr_sig) == '0)); // R3
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst) (clr && !st_valid) |=> (wr_sig == '0)); // R7
    AST_CONFLICT_IDLE: assert property (@(posedge clk) disable iff (rst) !rmt_valid |=> !conflict); // R6
endmodule

bind bloom_sig_unit sig_unit_checker #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .BANK_W(BANK_W), .ROT_STEP(ROT_STEP)
) u_sig_chk (
    .clk(clk), .rst(rst), .clr(clr), .st_valid(st_valid), .st_addr(st_addr),
    .rmt_valid(rmt_valid), .conflict(conflict), .wr_sig(wr_sig)
);

// File: tb/sim_bloom_sig_unit.sv
`timescale 1ns/1ps
module sim_bloom_sig_unit;
    localparam int AW = 32;
    localparam int NB = 4;
    localparam int BW = 512;
    localparam int IW = 9;
    localparam int SW = NB * BW;

    typedef enum logic [1:0] {OP_LD, OP_ST, OP_PRB, OP_RMT} op_t;
    typedef struct packed { op_t op; logic [AW-1:0] addr; } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{OP_PRB, 32'h0000_1000},
        '{OP_LD,  32'h0000_1000},
        '{OP_PRB, 32'h0000_1000},
        '{OP_ST,  32'hDEAD_BEEF},
        '{OP_PRB, 32'hDEAD_BEEF},
        '{OP_LD,  32'h8000_0004},
        '{OP_ST,  32'h0000_0040},
        '{OP_RMT, 32'h0000_1000},
        '{OP_RMT, 32'hDEAD_BEEF},
        '{OP_RMT, 32'h1234_5678},
        '{OP_PRB, 32'h8000_0004},
        '{OP_PRB, 32'h0BAD_F00D},
        '{OP_LD,  32'hFFFF_FFFF},
        '{OP_RMT, 32'hFFFF_FFFF},
        '{OP_PRB, 32'h0000_0040},
        '{OP_RMT, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst, clr, ld_valid, st_valid, rmt_valid;
    logic [AW-1:0] ld_addr, st_addr, probe_addr;
    logic [SW-1:0] rmt_sig, wr_sig;
    logic          probe_rd_hit, probe_wr_hit, conflict;

    logic [SW-1:0] rd_m, wr_m;
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bloom_sig_unit u0 (
        .clk(clk), .rst(rst), .clr(clr),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .rmt_valid(rmt_valid), .rmt_sig(rmt_sig),
        .probe_addr(probe_addr),
        .probe_rd_hit(probe_rd_hit), .probe_wr_hit(probe_wr_hit),
        .conflict(conflict), .wr_sig(wr_sig)
    );

    // Hash as written in R2
    function automatic int bidx(logic [AW-1:0] a, int k);
        logic [AW-1:0] r;
        logic [IW-1:0] f;
        r = (a << (5*k)) | (a >> (AW - 5*k));
        if (k == 0) r = a;
        f = '0;
        for (int j = 0; j < AW; j += IW) begin
            f = f ^ IW'(r >> j);
        end
        return k*BW + int'(f);
    endfunction

    function automatic logic [SW-1:0] mark(logic [SW-1:0] s, logic [AW-1:0] a);
        for (int k = 0; k < NB; k++) s[bidx(a, k)] = 1'b1;
        return s;
    endfunction

    function automatic bit holds(logic [SW-1:0] s, logic [AW-1:0] a);
        bit h = 1'b1;
        for (int k = 0; k < NB; k++) h = h & s[bidx(a, k)];
        return h;
    endfunction

    function automatic bit meets(logic [SW-1:0] a, logic [SW-1:0] b);
        bit m = 1'b1;
        for (int k = 0; k < NB; k++) m = m & (|(a[k*BW +: BW] & b[k*BW +: BW]));
        return m;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_sig(string req);
        chk(wr_sig == wr_m, req, "wr_sig differs, ones", $countones(wr_sig), $countones(wr_m));
    endtask

    task automatic probe(logic [AW-1:0] a, string req);
        probe_addr = a;
        #1;
        chk(probe_rd_hit == holds(rd_m, a), req, "probe_rd_hit", probe_rd_hit, holds(rd_m, a));
        chk(probe_wr_hit == holds(wr_m, a), req, "probe_wr_hit", probe_wr_hit, holds(wr_m, a));
    endtask

    task automatic remote(logic [SW-1:0] s, string req);
        bit exp;
        exp = meets(s, rd_m) || meets(s, wr_m);
        rmt_sig = s; rmt_valid = 1'b1;
        @(negedge clk);
        rmt_valid = 1'b0;
        chk(conflict == exp, req, "conflict", conflict, exp);
    endtask

    task automatic insert(op_t op, logic [AW-1:0] a, bit with_clr);
        clr = with_clr;
        if (op == OP_LD) begin ld_valid = 1'b1; ld_addr = a; end
        else begin st_valid = 1'b1; st_addr = a; end
        @(posedge clk);
        if (with_clr) begin rd_m = '0; wr_m = '0; end
        if (op == OP_LD) rd_m = mark(rd_m, a); else wr_m = mark(wr_m, a);
        @(negedge clk);
        ld_valid = 1'b0; st_valid = 1'b0; clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [SW-1:0] s;
        rst = 1'b1; clr = 1'b0; ld_valid = 1'b0; st_valid = 1'b0; rmt_valid = 1'b0;
        ld_addr = '0; st_addr = '0; probe_addr = '0; rmt_sig = '0;
        rd_m = '0; wr_m = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(conflict == 1'b0, "R1", "conflict after reset", conflict, 0);
        chk(wr_sig == '0, "R1", "wr_sig ones after reset", $countones(wr_sig), 0);
        probe(32'h0000_1000, "R1");
        rst = 1'b0;
        @(negedge clk);

        // Vector table walk
        foreach (VECS[i]) begin
            case (VECS[i].op)
                OP_LD, OP_ST: begin
                    insert(VECS[i].op, VECS[i].addr, 1'b0);
                    chk_sig("R3");
                    probe(VECS[i].addr, "R4");
                end
                OP_PRB: probe(VECS[i].addr, "R4");
                default: remote(mark('0, VECS[i].addr), "R5");
            endcase
        end

        // R9 remote holding a loaded address plus noise always conflicts
        s = mark('0, 32'h8000_0004);
        s = mark(s, 32'h7777_0000);
        chk(meets(s, rd_m), "R9", "model overlap", 0, 1);
        remote(s, "R9");
        chk(conflict == 1'b1, "R9", "conflict on real overlap", conflict, 1);

        // R6 idle remote gives no conflict
        @(negedge clk);
        chk(conflict == 1'b0, "R6", "conflict while idle", conflict, 0);

        // R8 three banks overlap, fourth empty
        s = rd_m | wr_m;
        s[3*BW +: BW] = '0;
        remote(s, "R8");
        chk(conflict == 1'b0, "R8", "conflict with one empty bank", conflict, 0);
        s[bidx(32'h0000_1000, 3)] = 1'b1;
        remote(s, "R8");
        chk(conflict == 1'b1, "R8", "conflict once all banks meet", conflict, 1);

        // R7 clear with a store in the same cycle
        insert(OP_ST, 32'h0000_0ABC, 1'b1);
        chk_sig("R7");
        probe(32'h0000_1000, "R7");
        chk(probe_rd_hit == 1'b0, "R7", "old load after clear", probe_rd_hit, 0);
        probe(32'h0000_0ABC, "R7");
        chk(probe_wr_hit == 1'b1, "R7", "store beside clear", probe_wr_hit, 1);

        // R2 exact bit positions of one store into an empty write set
        insert(OP_LD, 32'h0000_0000, 1'b1);
        chk(wr_sig == '0, "R2", "wr_sig empty after clear", $countones(wr_sig), 0);
        insert(OP_ST, 32'h0001_0203, 1'b0);
        for (int k = 0; k < NB; k++) begin
            chk(wr_sig[bidx(32'h0001_0203, k)] == 1'b1, "R2", "hashed bit set, bank", k, k);
        end
        chk($countones(wr_sig) == NB, "R2", "ones in wr_sig", $countones(wr_sig), NB);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule